// File: doc/BRIEF.md
# Clockless-Handshake Read Memory Responder

This block is the memory end of a read-only transfer link on which the two parties share no clock. A requester places an address on a shared data bundle and signals a request; the responder captures the address, answers with an acknowledge, waits for the request to be withdrawn and the acknowledge to be released, and only then returns the stored word with a data-ready strobe. The requester takes the word, acknowledges it, and the responder stops driving and clears its data-ready strobe. The transfer closes once the requester withdraws its own acknowledge. Every edge on either side waits for the other party to respond.

The requester's request and acknowledge lines enter through two-flop synchronizers. The memory access delay is counted in local cycles from the moment the address acknowledge rises, so the access overlaps the address-release steps. The stored words are fixed contents computed from the word index. The bidirectional bundle is split at the block edge into a sampled input, a driven output and a drive enable.

Top module: `hs_mem_responder`

## Requirements
- R1: After reset, the responder acknowledge, the data-ready strobe and the drive enable are all low.
- R2: A request held high for at least four cycles raises the responder acknowledge. The address is taken from the low log2(DEPTH) bits of the data bundle while the request is high, and the upper bundle bits are ignored.
- R3: The responder acknowledge stays high for as long as the request stays high, and falls once the request has been seen low.
- R4: The data-ready strobe is never high while the responder acknowledge is high, and it rises only after the responder acknowledge has fallen.
- R5: The returned word for address a equals ((a × 0x0123) XOR 0xA5C3) truncated to DATA_W bits.
- R6: The data-ready strobe and the driven word stay unchanged until the requester acknowledge is seen high. The strobe then falls.
- R7: The drive enable is high exactly when the data-ready strobe is high, and it falls in the same cycle as the strobe.
- R8: While the requester acknowledge stays high after a transfer, a new request is not acknowledged. It is acknowledged only after the requester acknowledge falls.
- R9: A request pulse lasting a single cycle is abandoned: no acknowledge, no data-ready strobe and no drive follow, and the next full request is served normally.
- R10: If the responder acknowledge rises in cycle A and falls in cycle F, the data-ready strobe rises in cycle max(A + ACCESS_CYC + 1, F + 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Responder clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req_i | input | 1 | Requester read request, asynchronous |
| req_ack_i | input | 1 | Requester acknowledge of returned data, asynchronous |
| bus_i | input | DATA_W | Sampled level of the shared data bundle |
| resp_ack_o | output | 1 | Responder acknowledge of the address |
| data_rdy_o | output | 1 | Returned word is on the bundle |
| bus_oe_o | output | 1 | Responder drives the bundle |
| bus_o | output | DATA_W | Word driven onto the bundle when enabled |

## Verification
The end of the access delay and the detection of the request falling can land in the same cycle. Whichever comes later decides when the data-ready strobe rises. The bench sweeps how long the requester holds its request, from well before the delay ends to well after it, including the exact cycle where both coincide. For each case it checks that the strobe rises in cycle max(A + ACCESS_CYC + 1, F + 1) and never overlaps the responder acknowledge.

// File: rtl/hs_resp_pkg.sv
// Package: shared state type and stored-word formula for the handshake responder.
// Assumes: consumers truncate rom_word to their own data width.
package hs_resp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUAL,
        ST_ADDR_ACK,
        ST_WAIT_DATA,
        ST_DRIVE,
        ST_CLOSE
    } resp_state_t;

    // Fixed content of word idx: (idx * 0x0123) xor 0xA5C3.
    function automatic logic [31:0] rom_word(input int unsigned idx);
        return (idx * 32'h0000_0123) ^ 32'h0000_A5C3;
    endfunction

endpackage

// File: rtl/hs_sync2.sv
// Two-flop synchronizer for a vector of independent asynchronous control lines.
// Assumes: each bit is a level signal that is stable for several clock cycles.
module hs_sync2 #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    // Two-stage capture of the asynchronous levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/hs_rom.sv
// Fixed-content word store with a registered address.
// Captures the address from the bundle on cap_en and presents the addressed word.
// Assumes: DATA_W > log2(DEPTH); the upper address bits of the bundle are ignored.
module hs_rom #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] addr_word,
    output logic [DATA_W-1:0] rd_word
);
    localparam int ADDR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] addr_q;
    logic              unused_hi;

    // Fixed contents, one entry per word index.
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign mem[g] = DATA_W'(hs_resp_pkg::rom_word(g));
    end

    // Latch the word address when the request is qualified.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (cap_en) begin
            addr_q <= addr_word[ADDR_W-1:0];
        end
    end

    assign unused_hi = ^addr_word[DATA_W-1:ADDR_W];
    assign rd_word   = mem[addr_q];
endmodule

// File: rtl/hs_resp_fsm.sv
// Handshake sequencer: qualifies a request, acknowledges the address, counts the
// access delay, drives the word under data-ready and closes on the requester acknowledge.
// Assumes: req_s and hack_s are already synchronized; ACCESS_CYC >= 1.
module hs_resp_fsm
    import hs_resp_pkg::*;
#(
    parameter int ACCESS_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic hack_s,
    output logic cap_en,
    output logic resp_ack,
    output logic data_rdy,
    output logic drive_en
);
    localparam int            CW      = $clog2(ACCESS_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(ACCESS_CYC);

    resp_state_t   st_q, st_n;
    logic [CW-1:0] cnt_q;
    logic          delay_done;

    assign delay_done = (cnt_q == CNT_MAX);
    assign cap_en     = (st_q == ST_QUAL) && req_s;

    // Next-state selection for the interlocked sequence.
    always_comb begin
        st_n = st_q;
        case (st_q)
            ST_IDLE:      if (req_s)      st_n = ST_QUAL;
            ST_QUAL:      st_n = req_s ? ST_ADDR_ACK : ST_IDLE;
            ST_ADDR_ACK:  if (!req_s)     st_n = ST_WAIT_DATA;
            ST_WAIT_DATA: if (delay_done) st_n = ST_DRIVE;
            ST_DRIVE:     if (hack_s)     st_n = ST_CLOSE;
            ST_CLOSE:     if (!hack_s)    st_n = ST_IDLE;
            default:      st_n = ST_IDLE;
        endcase
    end

    // State and glitch-free registered handshake outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            resp_ack <= 1'b0;
            data_rdy <= 1'b0;
            drive_en <= 1'b0;
        end else begin
            st_q     <= st_n;
            resp_ack <= (st_n == ST_ADDR_ACK);
            data_rdy <= (st_n == ST_DRIVE);
            drive_en <= (st_n == ST_DRIVE);
        end
    end

    // Access-delay counter: restarts when the address acknowledge rises, saturates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (st_q == ST_QUAL && st_n == ST_ADDR_ACK) begin
            cnt_q <= '0;
        end else if (!delay_done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hs_mem_responder.sv
// Top: memory responder for a clockless request/acknowledge read link with a
// shared address/data bundle. Synchronizes the requester lines, then sequences.
// Assumes: the requester holds the address on the bundle while its request is high.
module hs_mem_responder #(
    parameter int DATA_W     = 16,
    parameter int DEPTH      = 16,
    parameter int ACCESS_CYC = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req_i,
    input  logic              req_ack_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic              resp_ack_o,
    output logic              data_rdy_o,
    output logic              bus_oe_o,
    output logic [DATA_W-1:0] bus_o
);
    logic [1:0] ctl_s;
    logic       cap_en;

    hs_sync2 #(.WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({req_ack_i, rd_req_i}),
        .sync_o  (ctl_s)
    );

    hs_rom #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rom (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .addr_word (bus_i),
        .rd_word   (bus_o)
    );

    hs_resp_fsm #(.ACCESS_CYC(ACCESS_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_s    (ctl_s[0]),
        .hack_s   (ctl_s[1]),
        .cap_en   (cap_en),
        .resp_ack (resp_ack_o),
        .data_rdy (data_rdy_o),
        .drive_en (bus_oe_o)
    );
endmodule

// File: rtl/hs_mem_responder_chk.sv
// Checker: port-level handshake properties of the responder, attached by bind.
// Assumes: a two-cycle synchronizer delay on the requester lines.
module hs_mem_responder_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req_i,
    input logic              resp_ack_o,
    input logic              data_rdy_o,
    input logic              bus_oe_o,
    input logic [DATA_W-1:0] bus_o
);
    // R4: data-ready never overlaps the address acknowledge.
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_ack_o && data_rdy_o));

    // R7: the drive enable tracks the data-ready strobe.
    a_r7_oe_tracks_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o == data_rdy_o);

    // R6: the driven word holds while data-ready stays high.
    a_r6_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rdy_o && $past(data_rdy_o)) |-> $stable(bus_o));

    // R2: the acknowledge rises only on a request seen through the synchronizer.
    a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_ack_o) |-> $past(rd_req_i, 2));

    // R3: the acknowledge falls only after the request was seen low.
    a_r3_ack_drop_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(resp_ack_o) |-> !$past(rd_req_i, 2));
endmodule

bind hs_mem_responder hs_mem_responder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req_i   (rd_req_i),
    .resp_ack_o (resp_ack_o),
    .data_rdy_o (data_rdy_o),
    .bus_oe_o   (bus_oe_o),
    .bus_o      (bus_o)
);

// File: tb/hs_mem_responder_tb.sv
// Directed bench acting as the requesting device on the handshake link.
module hs_mem_responder_tb;
    localparam int CLK_P  = 10;
    localparam int DW     = 16;
    localparam int DEP    = 16;
    localparam int AC     = 12;
    localparam int TMO    = 300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req = 1'b0;
    logic          hack = 1'b0;
    logic [DW-1:0] bus_in = '0;
    logic          resp_ack, data_rdy, bus_oe;
    logic [DW-1:0] bus_out;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    int t_rise, t_fall, t_rdy;
    logic [DW-1:0] held_word;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hs_mem_responder #(.DATA_W(DW), .DEPTH(DEP), .ACCESS_CYC(AC)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req), .req_ack_i(hack),
        .bus_i(bus_in), .resp_ack_o(resp_ack), .data_rdy_o(data_rdy),
        .bus_oe_o(bus_oe), .bus_o(bus_out));

    function automatic logic [DW-1:0] exp_word(input int a);
        return DW'((a * 32'h0123) ^ 32'hA5C3);
    endfunction

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Wait at negedges until the chosen output (0 ack, 1 rdy) equals val.
    task automatic wait_out(input int which, input logic val, input string req);
        int n = 0;
        logic cur;
        do begin
            @(negedge clk);
            cur = (which == 0) ? resp_ack : data_rdy;
            n++;
        end while (cur !== val && n < TMO);
        if (cur !== val) check(1'b0, req, cur, val);
    endtask

    task automatic req_phase(input int a);
        @(negedge clk);
        rd_req = 1'b1;
        bus_in = {4'hC, 8'h5A, 4'(a)};            // upper bits junk: R2 ignores them
        wait_out(0, 1'b1, "R2 ack rise");
        t_rise = cyc;
        check(resp_ack == 1'b1 && data_rdy == 1'b0, "R2 ack up, no rdy", resp_ack, 1);
    endtask

    task automatic rest_phase(input int a, input int hold, input bit keep_hack);
        int exp_rdy;
        repeat (hold) @(negedge clk);
        check(resp_ack == 1'b1, "R3 ack held while req high", resp_ack, 1);
        rd_req = 1'b0;
        bus_in = 16'h0F0F;
        wait_out(0, 1'b0, "R3 ack fall");
        t_fall = cyc;
        wait_out(1, 1'b1, "R6 rdy rise");
        t_rdy = cyc;
        check(resp_ack == 1'b0, "R4 ack low at rdy", resp_ack, 0);
        check(bus_oe == 1'b1, "R7 oe with rdy", bus_oe, 1);
        check(bus_out == exp_word(a), "R5 word", bus_out, exp_word(a));
        exp_rdy = (t_rise + AC + 1 > t_fall + 1) ? t_rise + AC + 1 : t_fall + 1;
        check(t_rdy == exp_rdy, "R10 rdy timing", t_rdy - t_rise, exp_rdy - t_rise);
        held_word = bus_out;
        repeat (4) @(negedge clk);
        check(data_rdy && bus_oe && bus_out == held_word, "R6 hold without hack", bus_out, held_word);
        hack = 1'b1;
        wait_out(1, 1'b0, "R6 rdy fall");
        check(bus_oe == 1'b0, "R7 oe falls with rdy", bus_oe, 0);
        if (!keep_hack) begin
            repeat (2) @(negedge clk);
            hack = 1'b0;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check(!resp_ack && !data_rdy && !bus_oe, "R1 reset outputs",
              {resp_ack, data_rdy, bus_oe}, 0);
    endtask

    task automatic t_sweep();
        for (int h = 0; h <= AC + 4; h++) begin
            req_phase(h % DEP);
            rest_phase(h % DEP, h, 1'b0);
        end
    endtask

    task automatic t_addrs();
        for (int a = DEP - 1; a >= 0; a -= 5) begin
            req_phase(a);
            rest_phase(a, 2, 1'b0);
        end
    endtask

    task automatic t_hack_block();
        int seen = 0;
        req_phase(3);
        rest_phase(3, 1, 1'b1);
        @(negedge clk);
        rd_req = 1'b1;
        bus_in = 16'h0009;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (resp_ack) seen++;
        end
        check(seen == 0, "R8 no ack while hack high", seen, 0);
        hack = 1'b0;
        wait_out(0, 1'b1, "R8 ack after hack low");
        t_rise = cyc;
        check(resp_ack == 1'b1, "R8 ack after hack low", resp_ack, 1);
        rest_phase(9, 1, 1'b0);
    endtask

    task automatic t_abandon();
        int seen = 0;
        @(negedge clk);
        rd_req = 1'b1;
        bus_in = 16'h0004;
        @(negedge clk);
        rd_req = 1'b0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (resp_ack || data_rdy || bus_oe) seen++;
        end
        check(seen == 0, "R9 short pulse abandoned", seen, 0);
        req_phase(6);
        rest_phase(6, 0, 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sweep();
        t_addrs();
        t_hack_block();
        t_abandon();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule